// File: doc/BRIEF.md
# Interrupt Priority and Vector Sequencer

This block sits beside a small 16-bit processor core. It collects every reason the core may be interrupted, picks one winner at a time, and hands the core the winner's 8-bit interrupt type together with the byte address of that type's entry in the vector table. The vector table lives in the lowest 1 KB of memory and holds 256 entries of four bytes each: a 16-bit offset followed by a 16-bit segment.

There are three kinds of source. Internal exceptions (divide error, single step, breakpoint, overflow) and the software-interrupt instruction arrive as one-cycle strobes. The software-interrupt instruction carries its own type. A non-maskable line is edge sensitive. The block holds each of these requests until it is serviced. An external maskable line is level sensitive. It is looked at only on an instruction-boundary strobe and only while the interrupt-enable flag is set. Its type comes from an external controller through two back-to-back acknowledge cycles.

Each accepted request gives one single-cycle `vec_valid` pulse. After that pulse the block stays busy until the core raises `core_done`. Requests that arrive while the block is busy are held for later.

Top module: `irq_vector_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `vec_valid`, `ack_o`, `vec_type` and `vec_addr` are all zero.
- R2: The fixed types are: divide error 0, single step 1, non-maskable 2, breakpoint 3, overflow 4.
- R3: A software interrupt reports the `sw_type` value given with its strobe, for any value from 0 to 255.
- R4: Whenever `vec_valid` is high, `vec_addr` equals `vec_type` times 4. This is a 10-bit byte address, so it always falls inside the 1 KB table.
- R5: When several requests are pending, they are serviced in this order, highest first: divide error, software interrupt, breakpoint, overflow, non-maskable, maskable, single step.
- R6: The non-maskable request is taken on a rising edge of `nmi_in` and held until it is serviced. `int_en` has no effect on it. Holding `nmi_in` high gives only one service.
- R7: A maskable request is accepted only in an idle cycle where `ext_req`, `int_en` and `insn_bound` are all high and no higher-priority request is pending. In any other case `ack_o` stays low.
- R8: An accepted maskable request drives `ack_o` high for exactly two consecutive cycles. The type is taken from `bus_data` at the end of the second of those cycles. `vec_valid` goes high in the cycle right after the second acknowledge cycle.
- R9: Each serviced request gives exactly one `vec_valid` pulse, one cycle long. No further pulse comes until `core_done` is seen high, in some cycle after the pulse.
- R10: When the block is idle and a held source is strobed in cycle t, `vec_valid` is high in cycle t+2.
- R11: Strobes and edges that arrive while the block is busy are held and serviced after `core_done`.
- R12: A software-interrupt strobe that arrives while an earlier software interrupt is still pending and not being granted is ignored. The earlier type is kept, and only one software service follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_in | input | 1 | Non-maskable request, taken on its rising edge |
| ext_req | input | 1 | Maskable request level from the external controller |
| int_en | input | 1 | Interrupt-enable flag for the maskable request |
| insn_bound | input | 1 | Instruction-boundary strobe from the core |
| exc_div | input | 1 | Divide-error strobe |
| exc_step | input | 1 | Single-step strobe |
| exc_brk | input | 1 | Breakpoint strobe |
| exc_ovf | input | 1 | Overflow strobe |
| sw_stb | input | 1 | Software-interrupt strobe |
| sw_type | input | 8 | Type carried by the software interrupt |
| bus_data | input | 8 | Data bus; gives the type in the second acknowledge cycle |
| core_done | input | 1 | Core has finished with the current vector |
| ack_o | output | 1 | Acknowledge to the external controller, active high |
| vec_valid | output | 1 | One-cycle pulse: type and address are valid |
| vec_type | output | 8 | Type of the serviced request |
| vec_addr | output | 10 | Byte address of the vector entry |

## Verification
The hardest case to reach is the maskable request competing with held sources. Because the maskable line is not latched, it wins only in a boundary cycle where nothing higher is pending. The stimulus first strobes non-maskable and single step together. One cycle later it holds `ext_req` and `insn_bound` high. The expected order is then non-maskable, maskable, single step, which confirms that the maskable line slots in between two held sources. A second hard case is the ordering of strobes against a busy sequencer. The stimulus repeats a software strobe while the block is waiting for `core_done`, and the random phase fires mixed source sets, sometimes with a maskable request that is enabled or disabled. For each set the bench checks the complete service order against a priority model.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  // Request slots in priority order: a lower index wins.
  localparam int NREQ    = 7;
  localparam int RQ_DIV  = 0;
  localparam int RQ_SW   = 1;
  localparam int RQ_BRK  = 2;
  localparam int RQ_OVF  = 3;
  localparam int RQ_NMI  = 4;
  localparam int RQ_EXT  = 5;
  localparam int RQ_STEP = 6;

  // Fixed interrupt types of the internal sources.
  localparam int TY_DIV  = 0;
  localparam int TY_STEP = 1;
  localparam int TY_NMI  = 2;
  localparam int TY_BRK  = 3;
  localparam int TY_OVF  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK1,
    ST_ACK2,
    ST_VALID,
    ST_WAIT
  } seq_state_e;

  // Fixed type of a slot. The software and maskable slots carry their own
  // type, so they return 0 here.
  function automatic int fixed_code(int idx);
    case (idx)
      RQ_DIV:  return TY_DIV;
      RQ_BRK:  return TY_BRK;
      RQ_OVF:  return TY_OVF;
      RQ_NMI:  return TY_NMI;
      RQ_STEP: return TY_STEP;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/irq_pending.sv
module irq_pending
  import irq_seq_pkg::*;
#(
  parameter int TYPE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_div,
  input  logic              exc_step,
  input  logic              exc_brk,
  input  logic              exc_ovf,
  input  logic              nmi_in,
  input  logic              sw_stb,
  input  logic [TYPE_W-1:0] sw_type,
  input  logic [NREQ-1:0]   clr,
  output logic [NREQ-1:0]   pend,
  output logic [TYPE_W-1:0] sw_type_q
);

  logic            nmi_q;
  logic [NREQ-1:0] set_v;

  // Edge detector for the non-maskable line.
  always_ff @(posedge clk) begin
    if (rst) nmi_q <= 1'b0;
    else     nmi_q <= nmi_in;
  end

  always_comb begin
    set_v          = '0;
    set_v[RQ_DIV]  = exc_div;
    set_v[RQ_SW]   = sw_stb;
    set_v[RQ_BRK]  = exc_brk;
    set_v[RQ_OVF]  = exc_ovf;
    set_v[RQ_NMI]  = nmi_in & ~nmi_q;
    set_v[RQ_EXT]  = 1'b0;          // the maskable level is never held here
    set_v[RQ_STEP] = exc_step;
  end

  // One sticky flag per slot. A new set wins over a clear in the same cycle.
  for (genvar i = 0; i < NREQ; i++) begin : g_slot
    logic flag_q;
    always_ff @(posedge clk) begin
      if (rst)           flag_q <= 1'b0;
      else if (set_v[i]) flag_q <= 1'b1;
      else if (clr[i])   flag_q <= 1'b0;
    end
    assign pend[i] = flag_q;
  end

  // The software type is captured only when its slot is free, or is being
  // freed in this cycle.
  always_ff @(posedge clk) begin
    if (rst)
      sw_type_q <= '0;
    else if (sw_stb && (!pend[RQ_SW] || clr[RQ_SW]))
      sw_type_q <= sw_type;
  end

  // R6: a held non-maskable request stays until it is granted.
  p_nmi_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (pend[RQ_NMI] && !clr[RQ_NMI]) |=> pend[RQ_NMI]);

  // R6: the non-maskable flag only rises after the line was seen high.
  p_nmi_edge_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pend[RQ_NMI]) |-> $past(nmi_in));

  // R12: a repeated strobe must not overwrite a pending software type.
  p_sw_keep_r12: assert property (@(posedge clk) disable iff (rst)
    (pend[RQ_SW] && !clr[RQ_SW]) |=> $stable(sw_type_q));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_seq_pkg::*;
#(
  parameter int TYPE_W = 8
) (
  input  logic [NREQ-1:0]   pend,
  input  logic              ext_ok,
  input  logic [TYPE_W-1:0] sw_type_q,
  output logic [NREQ-1:0]   grant,
  output logic [TYPE_W-1:0] win_type
);

  logic [NREQ-1:0] req;

  always_comb begin
    req         = pend;
    req[RQ_EXT] = ext_ok;
  end

  // The lowest set bit is the winner.
  assign grant = req & (~req + 1'b1);

  always_comb begin
    win_type = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (grant[i]) begin
        if (i == RQ_SW) win_type = sw_type_q;
        else            win_type = TYPE_W'(fixed_code(i));
      end
    end
  end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int TYPE_W           = 8,
  parameter int ENTRY_BYTES_LOG2 = 2,
  localparam int ADDR_W          = TYPE_W + ENTRY_BYTES_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREQ-1:0]   grant,
  input  logic [TYPE_W-1:0] win_type,
  input  logic [TYPE_W-1:0] bus_data,
  input  logic              core_done,
  output logic [NREQ-1:0]   clr,
  output logic              ack_o,
  output logic              vec_valid,
  output logic [TYPE_W-1:0] vec_type,
  output logic [ADDR_W-1:0] vec_addr
);

  seq_state_e state;

  // Pending flags are cleared only when a grant is taken.
  assign clr = (state == ST_IDLE) ? grant : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ack_o     <= 1'b0;
      vec_valid <= 1'b0;
      vec_type  <= '0;
      vec_addr  <= '0;
    end else begin
      vec_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (grant[RQ_EXT]) begin
            state <= ST_ACK1;
            ack_o <= 1'b1;
          end else if (|grant) begin
            state     <= ST_VALID;
            vec_valid <= 1'b1;
            vec_type  <= win_type;
            vec_addr  <= {win_type, {ENTRY_BYTES_LOG2{1'b0}}};
          end
        end
        ST_ACK1: state <= ST_ACK2;    // first cycle only signals acceptance
        ST_ACK2: begin
          ack_o     <= 1'b0;
          vec_valid <= 1'b1;
          vec_type  <= bus_data;
          vec_addr  <= {bus_data, {ENTRY_BYTES_LOG2{1'b0}}};
          state     <= ST_VALID;
        end
        ST_VALID: state <= ST_WAIT;
        ST_WAIT:  if (core_done) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R9: the valid pulse is one cycle long.
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);

  // R8: the acknowledge lasts at least two cycles.
  p_ack_two_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |=> ack_o);

  // R8: the acknowledge ends after two cycles, and valid follows at once.
  p_ack_end_r8: assert property (@(posedge clk) disable iff (rst)
    (ack_o && $past(ack_o)) |=> (!ack_o && vec_valid));

  // R4: the address is the type scaled to the entry size.
  p_addr_r4: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_addr[ENTRY_BYTES_LOG2-1:0] == '0 &&
                   vec_addr[ADDR_W-1:ENTRY_BYTES_LOG2] == vec_type));

endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq
  import irq_seq_pkg::*;
#(
  parameter int TYPE_W           = 8,
  parameter int ENTRY_BYTES_LOG2 = 2,
  localparam int ADDR_W          = TYPE_W + ENTRY_BYTES_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_in,
  input  logic              ext_req,
  input  logic              int_en,
  input  logic              insn_bound,
  input  logic              exc_div,
  input  logic              exc_step,
  input  logic              exc_brk,
  input  logic              exc_ovf,
  input  logic              sw_stb,
  input  logic [TYPE_W-1:0] sw_type,
  input  logic [TYPE_W-1:0] bus_data,
  input  logic              core_done,
  output logic              ack_o,
  output logic              vec_valid,
  output logic [TYPE_W-1:0] vec_type,
  output logic [ADDR_W-1:0] vec_addr
);

  logic [NREQ-1:0]   pend;
  logic [NREQ-1:0]   grant;
  logic [NREQ-1:0]   clr;
  logic [TYPE_W-1:0] sw_type_q;
  logic [TYPE_W-1:0] win_type;
  logic              ext_ok;

  // The maskable level only counts at a boundary while it is enabled.
  assign ext_ok = ext_req & int_en & insn_bound;

  irq_pending #(.TYPE_W(TYPE_W)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .exc_div   (exc_div),
    .exc_step  (exc_step),
    .exc_brk   (exc_brk),
    .exc_ovf   (exc_ovf),
    .nmi_in    (nmi_in),
    .sw_stb    (sw_stb),
    .sw_type   (sw_type),
    .clr       (clr),
    .pend      (pend),
    .sw_type_q (sw_type_q)
  );

  irq_arbiter #(.TYPE_W(TYPE_W)) u_arb (
    .pend      (pend),
    .ext_ok    (ext_ok),
    .sw_type_q (sw_type_q),
    .grant     (grant),
    .win_type  (win_type)
  );

  irq_seq_fsm #(
    .TYPE_W           (TYPE_W),
    .ENTRY_BYTES_LOG2 (ENTRY_BYTES_LOG2)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .grant     (grant),
    .win_type  (win_type),
    .bus_data  (bus_data),
    .core_done (core_done),
    .clr       (clr),
    .ack_o     (ack_o),
    .vec_valid (vec_valid),
    .vec_type  (vec_type),
    .vec_addr  (vec_addr)
  );

  // R7: an acknowledge starts only after an enabled request at a boundary.
  p_ext_gate_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(ext_req && int_en && insn_bound));

  // R1: the first cycle after reset shows nothing.
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!vec_valid && !ack_o));

endmodule

// File: tb/tb_irq_vector_seq.sv
`timescale 1ns/1ps
module tb_irq_vector_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nmi_in = 0, ext_req = 0, int_en = 0, insn_bound = 0;
  logic       exc_div = 0, exc_step = 0, exc_brk = 0, exc_ovf = 0, sw_stb = 0;
  logic [7:0] sw_type = 0, bus_data = 0;
  logic       core_done = 0;
  logic       ack_o, vec_valid;
  logic [7:0] vec_type;
  logic [9:0] vec_addr;

  int   checks = 0, errors = 0;
  int   ack_run = 0, ack_total = 0;
  logic [7:0] ext_type = 8'h00;
  bit   finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  irq_vector_seq dut (
    .clk(clk), .rst(rst), .nmi_in(nmi_in), .ext_req(ext_req),
    .int_en(int_en), .insn_bound(insn_bound), .exc_div(exc_div),
    .exc_step(exc_step), .exc_brk(exc_brk), .exc_ovf(exc_ovf),
    .sw_stb(sw_stb), .sw_type(sw_type), .bus_data(bus_data),
    .core_done(core_done), .ack_o(ack_o), .vec_valid(vec_valid),
    .vec_type(vec_type), .vec_addr(vec_addr)
  );

  task automatic chk(input bit ok, input string tag, input string msg,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, msg, act, exp);
    end
  endtask

  // External controller model: junk in the first acknowledge cycle and the
  // type in the second. It drops its request once acknowledged.
  always @(negedge clk) begin
    if (!rst) begin
      if (ack_o) begin
        ack_run++;
        if (ack_run == 1) begin
          bus_data = ~ext_type;
          ext_req  = 1'b0;
          ack_total++;
        end else begin
          bus_data = ext_type;
        end
      end else begin
        if (ack_run != 0) chk(ack_run == 2, "R8", "ack run length", ack_run, 2);
        ack_run = 0;
      end
    end
  end

  function automatic logic [7:0] exp_type(int idx, logic [7:0] swt);
    case (idx)
      0: return 8'd0;
      1: return swt;
      2: return 8'd3;
      3: return 8'd4;
      4: return 8'd2;
      default: return 8'd1;
    endcase
  endfunction

  // Slot bits: 0 div, 1 sw, 2 brk, 3 ovf, 4 nmi, 6 step.
  task automatic fire(input logic [6:0] b, input logic [7:0] swt);
    exc_div = b[0]; sw_stb = b[1]; sw_type = swt; exc_brk = b[2];
    exc_ovf = b[3]; nmi_in = b[4]; exc_step = b[6];
    @(negedge clk);
    exc_div = 0; sw_stb = 0; exc_brk = 0; exc_ovf = 0; nmi_in = 0;
    exc_step = 0;
  endtask

  task automatic wait_check(input logic [7:0] et, input string tag);
    bit seen = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (vec_valid) begin seen = 1; break; end
    end
    chk(seen, tag, "valid pulse seen", int'(seen), 1);
    chk(vec_type == et, tag, "vec_type", vec_type, et);
    chk(vec_addr == {et, 2'b00}, "R4", "vec_addr", vec_addr, {et, 2'b00});
  endtask

  task automatic release_vec();
    @(negedge clk);
    chk(!vec_valid, "R9", "pulse longer than one cycle", vec_valid, 0);
    repeat (3) begin
      @(negedge clk);
      chk(!vec_valid, "R9", "pulse before core_done", vec_valid, 0);
    end
    core_done = 1;
    @(negedge clk);
    core_done = 0;
  endtask

  task automatic expect_vec(input logic [7:0] et, input string tag);
    wait_check(et, tag);
    release_vec();
  endtask

  task automatic quiet(input int n, input string tag);
    bit bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (vec_valid || ack_o) bad = 1;
    end
    chk(!bad, tag, "unexpected activity", int'(bad), 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run hung actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0] bits;
    logic [7:0] swt;
    int acks0;
    void'($urandom(32'd4242));

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!vec_valid && !ack_o, "R1", "outputs in reset", {vec_valid, ack_o}, 0);
    rst = 0;
    @(negedge clk);
    chk(vec_type == 0 && vec_addr == 0 && !vec_valid && !ack_o, "R1",
        "outputs after reset", vec_addr, 0);

    // R10 timing and R2 for divide error
    fire(7'b0000001, 8'h00);
    chk(!vec_valid, "R10", "valid too early", vec_valid, 0);
    @(negedge clk);
    chk(vec_valid, "R10", "valid at t+2", vec_valid, 1);
    chk(vec_type == 0, "R2", "divide type", vec_type, 0);
    release_vec();

    // R2 the other fixed types, one at a time
    fire(7'b1000000, 0); expect_vec(8'd1, "R2");
    fire(7'b0000100, 0); expect_vec(8'd3, "R2");
    fire(7'b0001000, 0); expect_vec(8'd4, "R2");
    fire(7'b0010000, 0); expect_vec(8'd2, "R2");

    // R3 software types at both ends and in the middle
    fire(7'b0000010, 8'h00); expect_vec(8'h00, "R3");
    fire(7'b0000010, 8'hFF); expect_vec(8'hFF, "R3");
    fire(7'b0000010, 8'h5A); expect_vec(8'h5A, "R3");

    // R5 all held sources at once
    fire(7'b1011111, 8'h77);
    expect_vec(8'd0, "R5"); expect_vec(8'h77, "R5"); expect_vec(8'd3, "R5");
    expect_vec(8'd4, "R5"); expect_vec(8'd2, "R5"); expect_vec(8'd1, "R5");
    quiet(5, "R5");

    // R5 maskable sits between non-maskable and single step
    fire(7'b1010000, 0);
    ext_type = 8'hC3; int_en = 1; insn_bound = 1; ext_req = 1;
    expect_vec(8'd2, "R5");
    expect_vec(8'hC3, "R5");
    expect_vec(8'd1, "R5");
    insn_bound = 0;
    quiet(5, "R5");

    // R7 gating of the maskable request
    acks0 = ack_total;
    int_en = 0; ext_req = 1; insn_bound = 1;
    quiet(10, "R7");
    int_en = 1; insn_bound = 0;
    quiet(10, "R7");
    chk(ack_total == acks0, "R7", "ack count while gated", ack_total, acks0);
    ext_type = 8'h9E;
    insn_bound = 1;
    @(negedge clk);
    insn_bound = 0;
    chk(ack_o, "R8", "ack in first cycle", ack_o, 1);
    @(negedge clk);
    chk(ack_o && !vec_valid, "R8", "ack in second cycle", ack_o, 1);
    @(negedge clk);
    chk(!ack_o && vec_valid, "R8", "valid after ack", vec_valid, 1);
    chk(vec_type == 8'h9E, "R8", "type from second ack cycle", vec_type, 8'h9E);
    release_vec();
    chk(ack_total == acks0 + 1, "R7", "one ack sequence", ack_total, acks0 + 1);

    // R6 non-maskable held high while disabled
    int_en = 0;
    nmi_in = 1;
    expect_vec(8'd2, "R6");
    quiet(10, "R6");
    nmi_in = 0;
    quiet(4, "R6");
    fire(7'b0010000, 0);
    expect_vec(8'd2, "R6");

    // R11 and R12 strobes while busy
    fire(7'b0000010, 8'h11);
    wait_check(8'h11, "R11");
    sw_stb = 1; sw_type = 8'h22; @(negedge clk);
    sw_type = 8'h33; exc_div = 1; @(negedge clk);
    sw_stb = 0; exc_div = 0;
    release_vec();
    expect_vec(8'd0, "R11");
    expect_vec(8'h22, "R12");
    quiet(10, "R12");

    // Random mixes against the priority model
    for (int it = 0; it < 150; it++) begin
      bit use_ext, en;
      bits = 7'($urandom) & 7'b1011111;
      if (bits == 0) bits = 7'b0000010;
      swt = 8'($urandom);
      use_ext = ($urandom % 3) == 0;
      en = $urandom % 2;
      ext_type = 8'($urandom);
      fire(bits, swt);
      if (use_ext) begin
        int_en = en; ext_req = 1; insn_bound = 1;
      end
      for (int s = 0; s < 7; s++) begin
        if (s == 5) begin
          if (use_ext && en) expect_vec(ext_type, "R5");
        end else if (bits[s]) begin
          expect_vec(exp_type(s, swt), "R5");
        end
      end
      insn_bound = 0; ext_req = 0;
      quiet(2, "R9");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule